// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Pulse Accumulator

This block counts already-synchronized single-cycle edge pulses in two 8-bit accumulators. In split mode each counter has its own edge input and its own enable. When the join input is high, the pair acts as one 16-bit accumulator: counter 1 is the high byte, counter 0 is the low byte, and only edge input 0 advances it. The individual enables are then ignored. Nothing outside the join input stops the joined counter.

An overflow flag records when the high byte rolls over. In saturation mode it also records an edge that arrives while counter 1 already sits at its maximum. The flag can be cleared in one of two ways. In normal mode, software writes a one to it. In fast-clear mode, any access to a count register clears it. An interrupt request follows the flag, gated by an enable. A small register port lets software read both counts and the flag, and load either count.

Top module: `pulse_acc_pair`

## Requirements
- R1: After reset, both counts, the overflow flag and the interrupt request are 0.
- R2: With the join input low, counter 0 adds one for each edge 0 pulse while its enable is 1, and counter 1 adds one for each edge 1 pulse while its enable is 1. A disabled counter keeps its value.
- R3: With the join input high, {counter 1, counter 0} adds one for each edge 0 pulse, whatever the per-counter enables are. Edge 1 pulses have no effect on either count.
- R4: With the join input high, an edge that moves the 16-bit value from 0xFFFF to 0x0000 sets the overflow flag.
- R5: In split mode with saturation off, counter 1 wraps from 0xFF to 0x00 and sets the flag. Counter 0 also wraps from 0xFF to 0x00, but this does not set the flag.
- R6: In split mode with saturation on, both counters hold at 0xFF instead of wrapping. An enabled edge 1 pulse while counter 1 is 0xFF sets the flag. In joined mode the saturation input is ignored and the 16-bit value wraps.
- R7: With fast-clear off, a write of bit 0 = 1 to address 2 clears the flag. A write of bit 0 = 0 leaves the flag unchanged.
- R8: With fast-clear on, writing 1 to address 2 does not clear the flag. Any read or write of address 0 or address 1 clears it.
- R9: If a set event and a clear fall in the same cycle, the flag ends up set.
- R10: A write to address 0 loads counter 0, and a write to address 1 loads counter 1. A write takes priority over an edge to the same counter in that cycle. In joined mode, a write to either count register discards that cycle's edge 0 pulse.
- R11: The interrupt output is 1 exactly while the flag is 1 and the interrupt enable is 1. It responds to the enable in the same cycle.
- R12: Read data is combinational. Address 0 returns counter 0, address 1 returns counter 1, address 2 returns the flag in bit 0 with zeros above it, and address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge0_i | input | 1 | Synchronized edge pulse, channel 0 |
| edge1_i | input | 1 | Synchronized edge pulse, channel 1 |
| join_en_i | input | 1 | Join both counters into one 16-bit accumulator |
| cnt0_en_i | input | 1 | Enable for counter 0 in split mode |
| cnt1_en_i | input | 1 | Enable for counter 1 in split mode |
| sat_mode_i | input | 1 | Hold at maximum instead of wrapping (split mode) |
| fast_clr_i | input | 1 | Clear the flag on count-register access |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| reg_addr_i | input | 2 | Register address: 0 count 0, 1 count 1, 2 flag |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| cnt0_o | output | 8 | Counter 0 value (low byte when joined) |
| cnt1_o | output | 8 | Counter 1 value (high byte when joined) |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two conditions are hard to reach from the ports: the 16-bit rollover, and the collision between a set event and a clear. Counting up to them from zero would take tens of thousands of edges. The stimulus therefore loads counts one step below the boundary through the register port and then applies a single edge. For the collision, one cycle carries both the edge that overflows counter 1 and the flag write. Fast-clear and the priority of writes over edges are also exercised by driving an edge and an access in the same cycle.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        ADDR_CNT0 = 2'd0,
        ADDR_CNT1 = 2'd1,
        ADDR_FLAG = 2'd2,
        ADDR_NONE = 2'd3
    } pacc_addr_e;
endpackage

// File: rtl/pacc_inc.sv
module pacc_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] val_i,
    input  logic         step_i,
    input  logic         sat_i,
    output logic [W-1:0] nxt_o
);
    localparam logic [W-1:0] MAX = '1;

    always_comb begin
        nxt_o = val_i;
        if (step_i) begin
            if (sat_i && (val_i == MAX)) nxt_o = val_i;
            else                         nxt_o = val_i + 1'b1;
        end
    end
endmodule

// File: rtl/pacc_ovf_flag.sv
module pacc_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R9: a set event leaves the flag high even under a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    // R7: a clear without a set drops the flag
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    // R7: with neither event the flag keeps its value
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_q));
endmodule

// File: rtl/pulse_acc_pair.sv
module pulse_acc_pair #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge0_i,
    input  logic             edge1_i,
    input  logic             join_en_i,
    input  logic             cnt0_en_i,
    input  logic             cnt1_en_i,
    input  logic             sat_mode_i,
    input  logic             fast_clr_i,
    input  logic             ovf_ie_i,
    input  logic [1:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic [CNT_W-1:0] cnt0_o,
    output logic [CNT_W-1:0] cnt1_o,
    output logic             ovf_flag_o,
    output logic             irq_o
);
    import pacc_pkg::*;

    localparam int              NCNT  = 2;
    localparam int              ACC_W = NCNT * CNT_W;
    localparam logic [CNT_W-1:0] MAX  = '1;

    typedef struct packed {
        logic [NCNT-1:0][CNT_W-1:0] cnt;
    } acc_state_t;

    acc_state_t state_d, state_q;

    pacc_addr_e       addr;
    logic [NCNT-1:0]  wr_cnt;
    logic [NCNT-1:0]  step;
    logic [NCNT-1:0]  sat;
    logic [CNT_W-1:0] inc_nxt [NCNT];
    logic             ovf_set;
    logic             flag_clr;
    logic             cnt_access;
    logic             flag;

    assign addr = pacc_addr_e'(reg_addr_i);

    // Incrementers, one per byte
    for (genvar i = 0; i < NCNT; i++) begin : g_inc
        pacc_inc #(.W(CNT_W)) i_inc (
            .val_i  (state_q.cnt[i]),
            .step_i (step[i]),
            .sat_i  (sat[i]),
            .nxt_o  (inc_nxt[i])
        );
    end

    always_comb begin
        wr_cnt[0]  = reg_wr_i && (addr == ADDR_CNT0);
        wr_cnt[1]  = reg_wr_i && (addr == ADDR_CNT1);
        cnt_access = (reg_wr_i || reg_rd_i) &&
                     ((addr == ADDR_CNT0) || (addr == ADDR_CNT1));
        if (join_en_i) begin
            step[0] = edge0_i && !wr_cnt[0] && !wr_cnt[1];
            step[1] = step[0] && (state_q.cnt[0] == MAX);
            sat     = '0;
        end else begin
            step[0] = cnt0_en_i && edge0_i && !wr_cnt[0];
            step[1] = cnt1_en_i && edge1_i && !wr_cnt[1];
            sat     = {NCNT{sat_mode_i}};
        end
        ovf_set = step[1] && (state_q.cnt[1] == MAX);
        if (fast_clr_i) flag_clr = cnt_access;
        else            flag_clr = reg_wr_i && (addr == ADDR_FLAG) && reg_wdata_i[0];

        for (int i = 0; i < NCNT; i++) begin
            state_d.cnt[i] = wr_cnt[i] ? reg_wdata_i : inc_nxt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    pacc_ovf_flag i_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .clr_i  (flag_clr),
        .flag_o (flag)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (addr)
            ADDR_CNT0: reg_rdata_o = state_q.cnt[0];
            ADDR_CNT1: reg_rdata_o = state_q.cnt[1];
            ADDR_FLAG: reg_rdata_o[0] = flag;
            default:   reg_rdata_o = '0;
        endcase
    end

    assign cnt0_o     = state_q.cnt[0];
    assign cnt1_o     = state_q.cnt[1];
    assign ovf_flag_o = flag;
    assign irq_o      = flag && ovf_ie_i;

    logic [ACC_W-1:0] acc_flat;
    assign acc_flat = state_q.cnt;

    // R10: a count write lands regardless of edges
    p_wr_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && addr == ADDR_CNT0) |=> (cnt0_o == $past(reg_wdata_i)));
    // R3: joined value advances by one per edge 0 pulse
    p_join_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (join_en_i && edge0_i && !reg_wr_i && acc_flat != '1)
        |=> (acc_flat == $past(acc_flat) + 1'b1));
    // R6: counter 1 holds at its maximum in saturation mode
    p_sat_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!join_en_i && sat_mode_i && cnt1_en_i && edge1_i && !reg_wr_i && cnt1_o == MAX)
        |=> (cnt1_o == MAX && ovf_flag_o));
    // R8: writing one to the flag in fast-clear mode keeps it set
    p_fast_no_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clr_i && reg_wr_i && addr == ADDR_FLAG && ovf_flag_o) |=> ovf_flag_o);
endmodule

// File: tb/test_pulse_acc_pair.sv
module test_pulse_acc_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       edge0 = 0, edge1 = 0, join_en = 0, en0 = 0, en1 = 0;
    logic       sat = 0, fast = 0, ie = 0, wr = 0, rd = 0;
    logic [1:0] addr = 2'd3;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, c0, c1;
    logic       flag, irq;
    int         nvec = 0, nbad = 0;

    always #4 clk = ~clk;

    pulse_acc_pair i_pulse_acc_pair (
        .clk(clk), .rst_n(rst_n), .edge0_i(edge0), .edge1_i(edge1),
        .join_en_i(join_en), .cnt0_en_i(en0), .cnt1_en_i(en1),
        .sat_mode_i(sat), .fast_clr_i(fast), .ovf_ie_i(ie),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .cnt0_o(c0), .cnt1_o(c1), .ovf_flag_o(flag), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one clock with the given strobes, returns at the following negedge
    task automatic cyc(input logic e0, input logic e1, input logic w, input logic r,
                       input logic [1:0] a, input logic [7:0] d);
        edge0 = e0; edge1 = e1; wr = w; rd = r; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        edge0 = 0; edge1 = 0; wr = 0; rd = 0; addr = 2'd3; wdata = 8'h00;
    endtask

    task automatic clear_all();
        fast = 0; join_en = 0; sat = 0; en0 = 0; en1 = 0; ie = 0;
        cyc(0, 0, 1, 0, 2'd2, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'h00);
        cyc(0, 0, 1, 0, 2'd1, 8'h00);
    endtask

    task automatic t_reset();
        chk("R1 cnt0", c0, 0); chk("R1 cnt1", c1, 0);
        chk("R1 flag", flag, 0); chk("R1 irq", irq, 0);
    endtask

    task automatic t_split();
        clear_all();
        en0 = 1;
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 2'd3, 0);
        cyc(0, 1, 0, 0, 2'd3, 0);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R2 cnt0 counts", c0, 3); chk("R2 cnt1 disabled", c1, 0);
        en1 = 1;
        cyc(1, 1, 0, 0, 2'd3, 0);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R2 cnt0 both", c0, 4); chk("R2 cnt1 counts", c1, 2);
    endtask

    task automatic t_join();
        clear_all();
        join_en = 1;
        cyc(0, 0, 1, 0, 2'd0, 8'hFE);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 2'd3, 0);
        chk("R3 carry hi", c1, 8'h01); chk("R3 carry lo", c0, 8'h01);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R3 edge1 ignored", {c1, c0}, 16'h0101);
        chk("R4 no flag yet", flag, 0);
    endtask

    task automatic t_join_wrap();
        clear_all();
        join_en = 1; sat = 1;
        cyc(0, 0, 1, 0, 2'd0, 8'hFF);
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(1, 0, 0, 0, 2'd3, 0);
        chk("R4 wrap value", {c1, c0}, 0); chk("R4 flag set", flag, 1);
        chk("R6 sat ignored joined", c0, 0);
        chk("R11 irq gated", irq, 0);
        ie = 1; #1;
        chk("R11 irq on", irq, 1);
        @(negedge clk);
        cyc(0, 0, 1, 0, 2'd2, 8'h01);
        chk("R7 w1c", flag, 0); chk("R11 irq off", irq, 0);
    endtask

    task automatic t_wrap8();
        clear_all();
        en0 = 1; en1 = 1;
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R5 cnt1 wraps", c1, 0); chk("R5 cnt1 flag", flag, 1);
        cyc(0, 0, 1, 0, 2'd2, 8'h01);
        cyc(0, 0, 1, 0, 2'd0, 8'hFF);
        cyc(1, 0, 0, 0, 2'd3, 0);
        chk("R5 cnt0 wraps", c0, 0); chk("R5 cnt0 no flag", flag, 0);
    endtask

    task automatic t_sat();
        clear_all();
        en0 = 1; en1 = 1; sat = 1;
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 0, 1, 0, 2'd0, 8'hFF);
        cyc(1, 0, 0, 0, 2'd3, 0);
        chk("R6 cnt0 holds", c0, 8'hFF); chk("R6 cnt0 no flag", flag, 0);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R6 cnt1 holds", c1, 8'hFF); chk("R6 flag", flag, 1);
    endtask

    task automatic t_clear();
        // flag is set from t_sat
        cyc(0, 0, 1, 0, 2'd2, 8'h00);
        chk("R7 write zero keeps", flag, 1);
        addr = 2'd2; #1;
        chk("R12 flag read", rdata, 1);
        addr = 2'd0; #1; chk("R12 cnt0 read", rdata, 8'hFF);
        addr = 2'd3; #1; chk("R12 addr3 read", rdata, 0);
        @(negedge clk);
        cyc(0, 0, 1, 0, 2'd2, 8'h01);
        chk("R7 write one clears", flag, 0);
    endtask

    task automatic t_fast();
        clear_all();
        en1 = 1;
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 1, 0, 0, 2'd3, 0);
        fast = 1;
        cyc(0, 0, 1, 0, 2'd2, 8'h01);
        chk("R8 w1c blocked", flag, 1);
        cyc(0, 0, 0, 1, 2'd0, 0);
        chk("R8 read clears", flag, 0);
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 1, 0, 0, 2'd3, 0);
        chk("R8 set again", flag, 1);
        cyc(0, 0, 1, 0, 2'd1, 8'h07);
        chk("R8 write clears", flag, 0); chk("R10 load cnt1", c1, 8'h07);
        fast = 0;
    endtask

    task automatic t_set_wins();
        clear_all();
        en1 = 1;
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 1, 1, 0, 2'd2, 8'h01);
        chk("R9 set over w1c", flag, 1); chk("R9 cnt1", c1, 0);
        fast = 1;
        cyc(0, 0, 1, 0, 2'd1, 8'hFF);
        cyc(0, 1, 0, 1, 2'd1, 0);
        chk("R9 set over fast clear", flag, 1);
        fast = 0;
    endtask

    task automatic t_wr_prio();
        clear_all();
        en0 = 1;
        cyc(1, 0, 1, 0, 2'd0, 8'h40);
        chk("R10 write beats edge", c0, 8'h40);
        join_en = 1;
        cyc(0, 0, 1, 0, 2'd0, 8'hFF);
        cyc(1, 0, 1, 0, 2'd1, 8'h05);
        chk("R10 joined edge dropped lo", c0, 8'hFF);
        chk("R10 joined hi loaded", c1, 8'h05);
    endtask

    initial begin
        #(8 * 200000);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_split();
        t_join();
        t_join_wrap();
        t_wrap8();
        t_sat();
        t_clear();
        t_fast();
        t_set_wins();
        t_wr_prio();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule